// File: doc/BRIEF.md
# Host Buffer RAM Access Port

This block connects a host bus to a 2 KB packet buffer held on chip. The host reaches the buffer in one of two ways. In memory-mapped mode, a memory-space cycle uses the host address as the RAM address. In I/O mode, the host loads an 11-bit pointer through two I/O registers. It then moves bytes through a single data-port register, and the pointer can advance after every data-port access.

A configuration register selects the access mode. The same register selects one of two cycle types for buffer accesses: one wait state, in which ready drops for one clock, or zero wait states, in which a zero-wait-state indication is pulsed. The third configuration bit, transmitter-off, goes straight to an output port. The buffer is an inferred synchronous RAM inside the block.

Register index in I/O space is taken from host address bits 1..0: 0 = configuration, 1 = pointer low, 2 = pointer high, 3 = data port.

Top module: `hbuf_port`

## Requirements
- R1: After reset the configuration register reads 0x80, the pointer is 0x000, auto-increment is off, pointer high reads 0x00, `tx_off` is 0 and `bus_rdy` is 1.
- R2: Configuration bit 7 selects one wait state (1) or zero wait states (0). Bit 6 selects I/O mode (1) or memory-mapped mode (0). Bit 0 is transmitter-off. The other bits read 0.
- R3: Pointer low (index 1) holds pointer bits 7..0. Pointer high (index 2) holds pointer bits 10..8 in bits 2..0 and auto-increment in bit 6. Its bits 7 and 5..3 read 0, and writes to them have no effect.
- R4: In memory-mapped mode, a memory-space access reads or writes RAM at `bus_addr[10:0]`. A data-port read returns 0, a data-port write leaves the RAM unchanged, and neither access moves the pointer.
- R5: In I/O mode, a data-port access reads or writes RAM at the pointer. A memory-space access is then ignored: a read returns 0 and a write changes nothing.
- R6: With auto-increment 1 in I/O mode, every data-port read or write advances the pointer by one, wrapping from 0x7FF to 0x000. A read returns the byte at the pointer value from before that advance.
- R7: With auto-increment 0, data-port accesses leave the pointer unchanged.
- R8: In zero-wait mode, a buffer access keeps `bus_rdy` high. `bus_zws` is high for exactly the cycle after the request edge, and read data is valid in that same cycle.
- R9: In one-wait mode, `bus_rdy` is low for exactly the one cycle after the request edge. Read data is valid once it rises again, and `bus_zws` stays low. A request presented while `bus_rdy` is low is ignored.
- R10: `tx_off` equals configuration bit 0 and changes only on a configuration write.
- R11: A pointer register write is used by the very next data-port access.
- R12: Register accesses (indices 0 to 2, and index 3 outside I/O mode) never drop `bus_rdy` and never raise `bus_zws`. Their read data is valid in the cycle after the request edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, sampled at a rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_io | input | 1 | 1 = I/O register space, 0 = memory space |
| bus_addr | input | 11 | Memory address, or register index in bits 1..0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the last completed read |
| bus_rdy | output | 1 | Ready; low during a wait state |
| bus_zws | output | 1 | Zero-wait-state indication |
| tx_off | output | 1 | Transmitter disable |

## Verification
Registered results appear in the cycle that follows the request edge: register read data, the zero-wait pulse and the drop of ready. The bench samples these at the falling edge after that request edge. In one-wait mode the RAM access runs one edge later, so the bench waits one more falling edge before it compares read data and the restored ready. The pointer is never observed directly: it is read back through the pointer registers or inferred from data-port contents, with an expected value that a bench model of the pointer and RAM updates per access.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;

  localparam int HB_AW  = 11;
  localparam int HB_DW  = 8;
  localparam int HB_LOW = 8;
  localparam int HB_HIW = HB_AW - HB_LOW;

  typedef enum logic [1:0] {
    RIDX_CFG  = 2'd0,
    RIDX_PLO  = 2'd1,
    RIDX_PHI  = 2'd2,
    RIDX_DATA = 2'd3
  } ridx_e;

  typedef struct packed {
    logic             we;
    logic             dport;
    logic [HB_AW-1:0] addr;
    logic [HB_DW-1:0] wdata;
  } hb_acc_t;

  function automatic logic [HB_AW-1:0] ptr_next(input logic [HB_AW-1:0] p);
    return p + {{(HB_AW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [HB_DW-1:0] cfg_image(input logic wt, input logic io,
                                                 input logic tx);
    return {wt, io, 5'b0, tx};
  endfunction

  function automatic logic [HB_DW-1:0] phi_image(input logic ai,
                                                 input logic [HB_HIW-1:0] hi);
    return {1'b0, ai, {(HB_DW-2-HB_HIW){1'b0}}, hi};
  endfunction

endpackage

// File: rtl/hbuf_regs.sv
module hbuf_regs
  import hbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  ridx_e            wr_idx,
  input  logic [HB_DW-1:0] wdata,
  input  logic             inc,
  output logic             cfg_wait,
  output logic             cfg_io,
  output logic             cfg_tx,
  output logic             auto_inc,
  output logic [HB_AW-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_wait <= 1'b1;
      cfg_io   <= 1'b0;
      cfg_tx   <= 1'b0;
      auto_inc <= 1'b0;
      ptr      <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        RIDX_CFG: begin
          cfg_wait <= wdata[7];
          cfg_io   <= wdata[6];
          cfg_tx   <= wdata[0];
        end
        RIDX_PLO: ptr[HB_LOW-1:0] <= wdata;
        RIDX_PHI: begin
          ptr[HB_AW-1:HB_LOW] <= wdata[HB_HIW-1:0];
          auto_inc            <= wdata[6];
        end
        default: ;
      endcase
    end else if (inc) begin
      ptr <= ptr_next(ptr);
    end
  end

endmodule

// File: rtl/hbuf_cycle_ctl.sv
module hbuf_cycle_ctl
  import hbuf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    wait_en,
  input  hb_acc_t acc_in,
  output logic    exec,
  output hb_acc_t exec_acc,
  output logic    busy,
  output logic    zws
);

  hb_acc_t pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      zws  <= 1'b0;
      pend <= '0;
    end else begin
      busy <= start & wait_en;
      zws  <= start & ~wait_en;
      if (start & wait_en) pend <= acc_in;
    end
  end

  assign exec     = busy | (start & ~wait_en);
  assign exec_acc = busy ? pend : acc_in;

endmodule

// File: rtl/hbuf_ram.sv
module hbuf_ram #(
  parameter int AW = 11,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/hbuf_port.sv
module hbuf_port
  import hbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic             bus_io,
  input  logic [HB_AW-1:0] bus_addr,
  input  logic [HB_DW-1:0] bus_wdata,
  output logic [HB_DW-1:0] bus_rdata,
  output logic             bus_rdy,
  output logic             bus_zws,
  output logic             tx_off
);

  logic             busy, acc_go, is_dport, is_mem, start_buf, reg_acc;
  logic             cfg_wr, ptr_wr, ptr_inc, exec;
  logic             cfg_wait, cfg_io, cfg_tx, auto_inc;
  logic [HB_AW-1:0] ptr, ram_addr;
  logic [HB_DW-1:0] ram_q, reg_q, reg_image;
  logic             src_ram;
  ridx_e            idx;
  hb_acc_t          acc_in, exec_acc;
  logic             wait_en;

  assign idx       = ridx_e'(bus_addr[1:0]);
  assign acc_go    = bus_req & ~busy;
  assign is_dport  = bus_io & (idx == RIDX_DATA) & cfg_io;
  assign is_mem    = ~bus_io & ~cfg_io;
  assign start_buf = acc_go & (is_dport | is_mem);
  assign reg_acc   = acc_go & bus_io & ~is_dport;
  assign cfg_wr    = reg_acc & bus_we & (idx == RIDX_CFG);
  assign ptr_wr    = reg_acc & bus_we & ((idx == RIDX_PLO) | (idx == RIDX_PHI));
  assign wait_en   = cfg_wait;

  assign acc_in = '{we: bus_we, dport: is_dport, addr: bus_addr, wdata: bus_wdata};

  hbuf_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_acc & bus_we),
    .wr_idx   (idx),
    .wdata    (bus_wdata),
    .inc      (ptr_inc),
    .cfg_wait (cfg_wait),
    .cfg_io   (cfg_io),
    .cfg_tx   (cfg_tx),
    .auto_inc (auto_inc),
    .ptr      (ptr)
  );

  hbuf_cycle_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_buf),
    .wait_en  (wait_en),
    .acc_in   (acc_in),
    .exec     (exec),
    .exec_acc (exec_acc),
    .busy     (busy),
    .zws      (bus_zws)
  );

  assign ram_addr = exec_acc.dport ? ptr : exec_acc.addr;
  assign ptr_inc  = exec & exec_acc.dport & auto_inc;

  hbuf_ram #(.AW(HB_AW), .DW(HB_DW)) u_ram (
    .clk   (clk),
    .we    (exec & exec_acc.we),
    .re    (exec & ~exec_acc.we),
    .addr  (ram_addr),
    .wdata (exec_acc.wdata),
    .rdata (ram_q)
  );

  always_comb begin
    reg_image = '0;
    if (bus_io) begin
      case (idx)
        RIDX_CFG: reg_image = cfg_image(cfg_wait, cfg_io, cfg_tx);
        RIDX_PLO: reg_image = ptr[HB_LOW-1:0];
        RIDX_PHI: reg_image = phi_image(auto_inc, ptr[HB_AW-1:HB_LOW]);
        default:  reg_image = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= '0;
      src_ram <= 1'b0;
    end else if (acc_go & ~bus_we & ~is_dport & ~is_mem) begin
      reg_q   <= reg_image;
      src_ram <= 1'b0;
    end else if (exec & ~exec_acc.we) begin
      src_ram <= 1'b1;
    end
  end

  assign bus_rdata = src_ram ? ram_q : reg_q;
  assign bus_rdy   = ~busy;
  assign tx_off    = cfg_tx;

endmodule

// File: rtl/hbuf_port_chk.sv
module hbuf_port_chk
  import hbuf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rdy,
  input logic             bus_zws,
  input logic             tx_off,
  input logic             start_buf,
  input logic             wait_en,
  input logic             ptr_inc,
  input logic             ptr_wr,
  input logic             cfg_wr,
  input logic [HB_AW-1:0] ptr
);

  AST_WAIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdy |=> bus_rdy); // R9
  AST_WAIT_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (start_buf && wait_en) |=> (!bus_rdy && !bus_zws)); // R9
  AST_ZWS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_buf && !wait_en) |=> (bus_zws && bus_rdy)); // R8
  AST_ZWS_ONLY_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    bus_zws |-> $past(start_buf && !wait_en)); // R12
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc |=> (ptr == ptr_next($past(ptr)))); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_inc && !ptr_wr) |=> $stable(ptr)); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(tx_off)); // R10

endmodule

bind hbuf_port hbuf_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rdy   (bus_rdy),
  .bus_zws   (bus_zws),
  .tx_off    (tx_off),
  .start_buf (start_buf),
  .wait_en   (wait_en),
  .ptr_inc   (ptr_inc),
  .ptr_wr    (ptr_wr),
  .cfg_wr    (cfg_wr),
  .ptr       (ptr)
);

// File: tb/hbuf_port_bench.sv
module hbuf_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_io = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rdy, bus_zws, tx_off;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  m_ram [2048];
  logic [10:0] m_ptr = '0;
  bit          m_wait = 1, m_io = 0, m_tx = 0, m_ai = 0;

  always #5 clk = ~clk;

  hbuf_port u_hbuf_port (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_io(bus_io),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .bus_zws(bus_zws), .tx_off(tx_off)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fill_val(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'h15};
  endfunction

  // Model read value for an access under the current model state
  function automatic logic [7:0] model_rd(input bit io, input logic [10:0] a);
    if (!io) return m_io ? 8'h00 : m_ram[a];
    case (a[1:0])
      2'd0:    return {m_wait, m_io, 5'b0, m_tx};
      2'd1:    return m_ptr[7:0];
      2'd2:    return {1'b0, m_ai, 3'b0, m_ptr[10:8]};
      default: return m_io ? m_ram[m_ptr] : 8'h00;
    endcase
  endfunction

  task automatic acc(input bit io, input bit we, input logic [10:0] a,
                     input logic [7:0] wd, input string tag);
    bit dp, mm, bufa, rdy0, zws0, wt0;
    logic [7:0] exp_rd;
    dp     = io && a[1:0] == 2'd3 && m_io;
    mm     = !io && !m_io;
    bufa   = dp || mm;
    wt0    = m_wait;
    exp_rd = model_rd(io, a);
    if (we) begin
      if (mm) m_ram[a] = wd;
      if (dp) m_ram[m_ptr] = wd;
      if (io && a[1:0] == 2'd0) begin m_wait = wd[7]; m_io = wd[6]; m_tx = wd[0]; end
      if (io && a[1:0] == 2'd1) m_ptr[7:0] = wd;
      if (io && a[1:0] == 2'd2) begin m_ptr[10:8] = wd[2:0]; m_ai = wd[6]; end
    end
    if (dp && m_ai) m_ptr = m_ptr + 11'd1;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_io = io; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_req = 0;
    rdy0 = bus_rdy; zws0 = bus_zws;
    if (!rdy0) begin
      @(posedge clk);
      @(negedge clk);
      chk("R9 ready back", {7'b0, bus_rdy}, 8'h01);
    end
    chk(bufa ? (wt0 ? "R9 ready" : "R8 ready") : "R12 ready", {7'b0, rdy0},
        {7'b0, !(bufa && wt0)});
    chk(bufa ? "R8 zws" : "R12 zws", {7'b0, zws0}, {7'b0, bufa && !wt0});
    if (!we) chk(tag, bus_rdata, exp_rd);
    chk("R10 tx_off", {7'b0, tx_off}, {7'b0, m_tx});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdy", {7'b0, bus_rdy}, 8'h01);
    chk("R1 tx_off", {7'b0, tx_off}, 8'h00);
    rst_n = 1;
    acc(1, 0, 11'd0, 0, "R1 cfg");
    acc(1, 0, 11'd1, 0, "R1 plo");
    acc(1, 0, 11'd2, 0, "R1 phi");
    // fill in memory mode, zero wait
    acc(1, 1, 11'd0, 8'h00, "R2");
    for (int i = 0; i < 2048; i++) acc(0, 1, 11'(i), fill_val(11'(i)), "R4");
    acc(0, 0, 11'h5A3, 0, "R4 mem read");
    acc(1, 1, 11'd0, 8'h80, "R2");
    acc(0, 0, 11'h123, 0, "R4 mem read wait");
    // config and pointer high field masks
    acc(1, 1, 11'd0, 8'hFF, "R2");
    acc(1, 0, 11'd0, 0, "R2 cfg readback");
    acc(1, 1, 11'd2, 8'hFF, "R3");
    acc(1, 0, 11'd2, 0, "R3 phi readback");
    // wrap with auto-increment, one wait state, I/O mode
    acc(1, 1, 11'd1, 8'hFF, "R11");
    acc(1, 0, 11'd3, 0, "R6 read at 0x7FF");
    acc(1, 0, 11'd3, 0, "R6 read after wrap");
    acc(1, 0, 11'd1, 0, "R6 plo after wrap");
    acc(1, 0, 11'd2, 0, "R6 phi after wrap");
    acc(1, 1, 11'd3, 8'hA5, "R6");
    acc(1, 1, 11'd1, 8'h01, "R11");
    acc(1, 0, 11'd3, 0, "R11 data at new ptr");
    // auto-increment off, zero wait
    acc(1, 1, 11'd0, 8'h40, "R2");
    acc(1, 1, 11'd2, 8'h03, "R7");
    acc(1, 1, 11'd1, 8'h10, "R11");
    acc(1, 0, 11'd3, 0, "R7 first read");
    acc(1, 1, 11'd3, 8'h3C, "R7");
    acc(1, 0, 11'd3, 0, "R7 same location");
    acc(1, 0, 11'd1, 0, "R7 plo unchanged");
    // I/O mode ignores memory space
    acc(0, 1, 11'h310, 8'hEE, "R5");
    acc(0, 0, 11'h310, 0, "R5 mem read zero");
    acc(1, 0, 11'd3, 0, "R5 ram unchanged");
    // memory mode ignores data port
    acc(1, 1, 11'd2, 8'h43, "R4");
    acc(1, 1, 11'd0, 8'h00, "R4");
    acc(1, 1, 11'd3, 8'h99, "R4");
    acc(1, 0, 11'd3, 0, "R4 dport read zero");
    acc(1, 0, 11'd1, 0, "R4 ptr unchanged");
    acc(0, 0, 11'h310, 0, "R4 ram unchanged");
    // request held during wait state is ignored
    acc(1, 1, 11'd0, 8'h80, "R9");
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_io = 0; bus_addr = 11'h0AA; bus_wdata = 8'h11;
    @(posedge clk);
    @(negedge clk);
    bus_addr = 11'h0BB; bus_wdata = 8'h22;
    @(posedge clk);
    @(negedge clk);
    bus_req = 0;
    m_ram[11'h0AA] = 8'h11;
    acc(0, 0, 11'h0BB, 0, "R9 busy request ignored");
    acc(0, 0, 11'h0AA, 0, "R9 first write kept");
    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      int unsigned r;
      logic [7:0] v;
      r = $urandom % 10;
      v = 8'($urandom);
      case (r)
        0: acc(1, 1, 11'd0, v, "R2");
        1: acc(1, 1, 11'd1, v, "R11");
        2: acc(1, 1, 11'd2, v, "R3");
        3: acc(1, 0, 11'({$urandom} % 3), 0, "R12 random reg read");
        default: begin
          if (m_io) acc(1, r[0], 11'(($urandom & 11'h7FC) | 3), v, "R6 random data port");
          else      acc(0, r[0], 11'($urandom), v, "R4 random mem");
        end
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule